// File: doc/BRIEF.md
# Bidirectional Parallel Port

This block is a general-purpose parallel port of up to sixteen signals. A processor controls it through two 16-bit registers on a simple register bus. One register is the data register, which is backed by an output latch. The other is the direction register, in which each bit makes one signal an input or an output. Each signal has its own output-enable line, so the pad ring can turn the latch value into a driven pin wherever the direction bit is set.

Reads of the data register are formed bit by bit. An output bit returns the output latch. An input bit returns the pin after it has passed through a two-stage synchronizer. A build-time mask lists which pads are really bonded out. An absent pad reads zero as an input and returns its latch as an output. A write to the data register always updates the latch, whatever the direction of each bit. So software can preload a value before it switches a signal to output, and the pin never shows the undefined latch contents left after reset.

Top module: `pport`

## Requirements
- R1: While `rstN` is low at a clock edge, every direction bit clears, so `pinOe` becomes all zero and a read with `regSel`=1 returns 0. Reset leaves the output latch undefined.
- R2: With `wrEn` high at a clock edge, `regSel`=0 writes `wrData` into the output latch only, and `regSel`=1 writes it into the direction register only. With `wrEn` low, neither register changes.
- R3: A read with `regSel`=1 returns the direction register as last written, combinationally.
- R4: `pinOe[i]` equals direction bit i (1 = output, 0 = input), and `pinOut` equals the output latch at all times.
- R5: A data write to a bit in input mode stores the value in the latch without enabling the pin. When that bit later becomes an output, the stored value is driven.
- R6: For a bonded input bit, a read with `regSel`=0 returns the pin through two flops. A `pinIn` change set up before clock edge k is visible after edge k+1 and not after edge k.
- R7: For an output bit, a read with `regSel`=0 returns the latch bit, not the pin.
- R8: A pad whose bit is 0 in `BOND_MASK` reads 0 in input mode, whatever its pin does.
- R9: A pad whose bit is 0 in `BOND_MASK` reads its latch bit in output mode.
- R10: Direction and read selection are independent per bit, so one read can mix latch bits and pin bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| regSel | input | 1 | Register select: 0 = data, 1 = direction |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for the selected register |
| pinIn | input | PORT_W | Pin levels from the pads |
| pinOut | output | PORT_W | Output latch towards the pads |
| pinOe | output | PORT_W | Per-signal output enable (direction bit) |

## Verification
Some properties are checked on every cycle:
- each register write reaches `pinOe` or `pinOut` one cycle later;
- the register that was not addressed stays unchanged;
- a direction read mirrors `pinOe`;
- output bits of a data read match the latch;
- unbonded input bits never read as 1.

Other behaviour can only be shown by the bench's scenarios, because it needs a history of stimulus:
- the exact two-cycle visibility of a pin change;
- a latch value preloaded in input mode that appears later, once the bit turns to output;
- mixed-direction read words built from chosen pin patterns;
- the direction clear under reset.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int REG_W = 16;

  // strobes from the register decode to the datapath
  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic rdDir;
  } pport_strobe_t;
endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic          wrEn,
  input  logic          regSel,
  output pport_strobe_t strb
);
  always_comb begin
    strb         = '0;
    strb.wrLatch = wrEn && !regSel;
    strb.wrDir   = wrEn &&  regSel;
    strb.rdDir   = regSel;
  end
endmodule

// File: rtl/pport_dpath.sv
module pport_dpath
  import pport_pkg::*;
#(
  parameter int               PORT_W    = 16,
  parameter logic [REG_W-1:0] BOND_MASK = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  pport_strobe_t     strb,
  input  logic [REG_W-1:0]  wrData,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [REG_W-1:0]  rdData
);
  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] syncA;
  logic [PORT_W-1:0] syncB;
  logic [PORT_W-1:0] pinRd;

  // output latch: no reset, contents undefined until written
  always_ff @(posedge clk) begin
    if (strb.wrLatch) latchQ <= wrData[PORT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          dirQ <= '0;
    else if (strb.wrDir) dirQ <= wrData[PORT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (BOND_MASK[i]) begin : g_bonded
      assign pinRd[i] = dirQ[i] ? latchQ[i] : syncB[i];
    end else begin : g_absent
      assign pinRd[i] = dirQ[i] & latchQ[i];
    end
  end

  always_comb begin
    rdData             = '0;
    rdData[PORT_W-1:0] = strb.rdDir ? dirQ : pinRd;
  end

  assign pinOut = latchQ;
  assign pinOe  = dirQ;
endmodule

// File: rtl/pport.sv
module pport
  import pport_pkg::*;
#(
  parameter int               PORT_W    = 16,
  parameter logic [REG_W-1:0] BOND_MASK = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe
);
  pport_strobe_t strb;

  pport_ctrl u_ctrl (
    .wrEn   (wrEn),
    .regSel (regSel),
    .strb   (strb)
  );

  pport_dpath #(.PORT_W(PORT_W), .BOND_MASK(BOND_MASK)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .rdData (rdData)
  );
endmodule

// File: rtl/pport_chk.sv
module pport_chk
  import pport_pkg::*;
#(
  parameter int               PORT_W    = 16,
  parameter logic [REG_W-1:0] BOND_MASK = 16'hFFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              regSel,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  rdData,
  input logic [PORT_W-1:0] pinIn,
  input logic [PORT_W-1:0] pinOut,
  input logic [PORT_W-1:0] pinOe
);
  logic [PORT_W-1:0] absentMask;
  assign absentMask = ~BOND_MASK[PORT_W-1:0];

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel) |=> pinOe == $past(wrData[PORT_W-1:0]));   // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regSel) |=> $stable(pinOe));                      // R2
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel) |=> pinOut == $past(wrData[PORT_W-1:0])); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !regSel) |=> $stable(pinOut));                    // R5
  AST_DIR_READ: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> rdData[PORT_W-1:0] == pinOe);                    // R3
  AST_OUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (rdData[PORT_W-1:0] & pinOe) == (pinOut & pinOe)); // R7
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (rdData[PORT_W-1:0] & ~pinOe & absentMask) == '0); // R8
endmodule

bind pport pport_chk #(.PORT_W(PORT_W), .BOND_MASK(BOND_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
  .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/pport_bench.sv
module pport_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [15:0] BOND = 16'h0FFF;

  typedef struct packed {
    logic        wr;
    logic        sel;
    logic [15:0] data;
    logic [15:0] pins;
    logic [15:0] expRd;
    logic [15:0] expOe;
    logic [15:0] expOut;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'hA5C3, 16'h0000, 16'h0000, 16'h0000, 16'hA5C3},
    '{1'b0, 1'b0, 16'h0000, 16'h1234, 16'h0234, 16'h0000, 16'hA5C3},
    '{1'b1, 1'b1, 16'h00FF, 16'h1234, 16'h00FF, 16'h00FF, 16'hA5C3},
    '{1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'h0FC3, 16'h00FF, 16'hA5C3},
    '{1'b1, 1'b1, 16'hF00F, 16'hFFFF, 16'hF00F, 16'hF00F, 16'hA5C3},
    '{1'b0, 1'b0, 16'h0000, 16'h0000, 16'hA003, 16'hF00F, 16'hA5C3},
    '{1'b1, 1'b0, 16'h5A3C, 16'h0F0F, 16'h5F0C, 16'hF00F, 16'h5A3C},
    '{1'b1, 1'b1, 16'h0000, 16'hAAAA, 16'h0000, 16'h0000, 16'h5A3C},
    '{1'b0, 1'b0, 16'h0000, 16'hAAAA, 16'h0AAA, 16'h0000, 16'h5A3C}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic regSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut;
  logic [W-1:0] pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport #(.PORT_W(W), .BOND_MASK(BOND)) u_pport (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    tick(1);
    wrEn = 1'b0;
  endtask

  initial begin
    tick(3);
    // R1: reset state
    regSel = 1'b1;
    chk("R1 dir after reset", rdData, 16'h0000);
    chk("R1 oe after reset", pinOe, 16'h0000);
    rstN = 1'b1;
    tick(1);

    // table walk: R2 R3 R4 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      pinIn = VECS[v].pins;
      if (VECS[v].wr) regWrite(VECS[v].sel, VECS[v].data);
      else tick(1);
      regSel = VECS[v].sel;
      tick(2);
      chk($sformatf("R10 read vector %0d", v), rdData, VECS[v].expRd);
      chk($sformatf("R4 oe vector %0d", v), pinOe, VECS[v].expOe);
      chk($sformatf("R2 latch vector %0d", v), pinOut, VECS[v].expOut);
    end

    // R6: two-cycle latency on input reads
    regSel = 1'b0;
    pinIn = 16'h0000;
    tick(3);
    pinIn = 16'h0555;
    tick(1);
    chk("R6 after one edge", rdData, 16'h0000);
    tick(1);
    chk("R6 after two edges", rdData, 16'h0555);

    // R8: absent pads stay 0 even with pins high in input mode
    pinIn = 16'hF000;
    tick(3);
    chk("R8 absent input", rdData, 16'h0000);

    // R5: preload in input mode, no drive, then enable
    regWrite(1'b0, 16'h3C96);
    chk("R5 no drive in input mode", pinOe, 16'h0000);
    chk("R5 latch holds preload", pinOut, 16'h3C96);
    regWrite(1'b1, 16'hFFFF);
    pinIn = 16'h0000;
    regSel = 1'b0;
    tick(2);
    chk("R5 preload driven", pinOut, 16'h3C96);
    chk("R7 output read ignores pins", rdData, 16'h3C96);
    chk("R9 absent output reads latch", rdData & 16'hF000, 16'h3000);

    // R2: wrEn low has no effect
    regSel = 1'b1; wrData = 16'h1111; wrEn = 1'b0;
    tick(2);
    chk("R2 idle leaves dir", rdData, 16'hFFFF);
    chk("R2 idle leaves latch", pinOut, 16'h3C96);

    // R1: reset mid-run clears direction
    rstN = 1'b0;
    tick(1);
    chk("R1 dir cleared", rdData, 16'h0000);
    chk("R1 oe cleared", pinOe, 16'h0000);
    rstN = 1'b1;
    tick(1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD*20000);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule